// File: doc/BRIEF.md
# Reconfigurable Datapath Level

This block is one level of a coarse-grained reconfigurable array. It runs a basic block that has already been translated into a configuration, so the processor pipeline does not have to step through it. A start pulse captures the input context (NIN words) and the configuration into registers. The configured matrix of functional units then works on those captured values. Results go into an output context register file, and a one-cycle done pulse marks the moment the new values are visible.

The level has ROWS independent rows. Each row chains COLS ALUs in series inside a single clock, so a row can resolve that many dependent operations in one cycle. The level also has one multiplier and MEMS load ports toward a data memory. Those paths need an extra cycle: a load address is presented for one cycle, and the memory returns the word one cycle later. When no long slot is enabled, the whole configuration completes one cycle after start. When any long slot is enabled, it completes two cycles after start.

Top module: `cgra_level`

## Requirements
- R1: After reset every output context word is zero, `done` is low and `ld_en` is all zero.
- R2: Each ALU slot's 16-bit configuration is {op[15:12], srcA[11:8], srcB[7:4], wb[3], dest[2:0]}. Slot index row*COLS+col sits at alu_cfg[index*16 +: 16]. The op codes are: 1 add, 2 sub (A-B), 3 and, 4 or, 5 xor, 6 shift left, 7 logical shift right, 8 arithmetic shift right (shift amount B[4:0]), 9 signed A<B, 10 unsigned A<B (result 1 or 0), 11 pass A.
- R3: For an operand select value s below NIN (8), the operand is input context word s. For s = NIN+k, the operand is the output of ALU column k of the same row, but only when k is less than the slot's own column. Every other select value (a forward or out-of-range reference) yields zero.
- R4: The five ALUs of a row chain combinationally. A five-deep dependent chain completes, and `done` pulses one cycle after start, when no multiplier or load slot is enabled.
- R5: Rows compute in parallel and independently, and each row writes its own destinations in the same commit.
- R6: The multiplier configuration is {en[9], srcA[8:6], srcB[5:3], dest[2:0]}, with the sources being context indices. The multiplier writes the low W bits of A*B.
- R7: Load port p is configured by mem_cfg[p*7 +: 7] = {en[6], addrsel[5:3], dest[2:0]}. `ld_en[p]` is high for exactly the one cycle after the start edge. `ld_addr` carries the low AW bits of the selected context word. The word on `ld_rdata` in the following cycle is written to dest.
- R8: If any multiplier or load slot is enabled, `done` pulses two cycles after start. `done` is never high for two cycles in a row.
- R9: An ALU slot with op 0, op 12 to 15, or wb = 0 writes nothing. Output words that no slot writes keep their value, and the output context changes only in a `done` cycle.
- R10: When several slots target the same output word, the last one in this order wins: ALU slots by ascending index, then the multiplier, then load port 0, then load port 1.
- R11: A start that arrives while a configuration is still in flight is ignored.
- R12: Context and configuration inputs are sampled only at an accepted start. Later changes do not affect the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one configuration |
| ctx_in | input | NIN*W | Input context words, word i at [i*W +: W] |
| alu_cfg | input | ROWS*COLS*16 | ALU slot configurations |
| mul_cfg | input | 10 | Multiplier configuration |
| mem_cfg | input | MEMS*7 | Load port configurations |
| ld_rdata | input | MEMS*W | Load data, valid one cycle after `ld_en` |
| ld_en | output | MEMS | Load request per port |
| ld_addr | output | MEMS*AW | Load address per port |
| out_ctx | output | NOUT*W | Output context words, word i at [i*W +: W] |
| done | output | 1 | One-cycle pulse when output context is updated |

## Verification
The bench sweeps every op code against operand pairs chosen to hit sign, zero and shift-amount edges. Each result is checked against arithmetic computed in the bench. A design that mixes up signed and unsigned compares, or that masks the shift amount wrongly, fails that sweep.

A five-deep dependent chain checks that each column sees its predecessors' results in the same cycle; a registered chain would return stale values or a late done. Forward column references and out-of-range selects must read zero. Colliding destinations must resolve in the stated order, so a design that reverses the order lets the wrong slot win.

The multiplier and load path are checked for the two-cycle done, for a one-cycle load strobe, and for the correct address. A start issued mid-flight with changed context must leave the first result intact.

// File: rtl/cgra_level_pkg.sv
`timescale 1ns/1ps
package cgra_level_pkg;
  localparam int OPW = 4;

  typedef enum logic [3:0] {
    OP_OFF  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_SLT  = 4'd9,
    OP_SLTU = 4'd10,
    OP_PASS = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/cgra_alu_row.sv
`timescale 1ns/1ps
module cgra_alu_row
  import cgra_level_pkg::*;
#(
  parameter int W    = 32,
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int COLS = 5
) (
  input  logic [NIN*W-1:0]                                                       ctx_flat,
  input  logic [COLS*(OPW+2*$clog2(NIN+COLS)+1+$clog2(NOUT))-1:0]                row_cfg,
  output logic [COLS*W-1:0]                                                      res,
  output logic [COLS-1:0]                                                        wr,
  output logic [COLS*$clog2(NOUT)-1:0]                                           dst
);
  localparam int SW   = $clog2(NIN + COLS);
  localparam int DW   = $clog2(NOUT);
  localparam int SLOT = OPW + 2*SW + 1 + DW;
  localparam int SHW  = $clog2(W);

  function automatic logic [W-1:0] alu_eval(input logic [OPW-1:0] op,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    logic [W-1:0] r;
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_SLL:  r = a << sh;
      OP_SRL:  r = a >> sh;
      OP_SRA:  r = $signed(a) >>> sh;
      OP_SLT:  r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_SLTU: r = {{(W-1){1'b0}}, (a < b)};
      OP_PASS: r = a;
      default: r = '0;
    endcase
    return r;
  endfunction

  // operand routing: context word, earlier column of this row, or zero
  function automatic logic [W-1:0] pick(input logic [SW-1:0] s,
                                        input logic [NIN*W-1:0] cx,
                                        input logic [COLS*W-1:0] av,
                                        input int col);
    int si;
    si = int'(s);
    if (si < NIN) return cx[si*W +: W];
    else if ((si - NIN) < col) return av[(si-NIN)*W +: W];
    else return '0;
  endfunction

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [SLOT-1:0]   sc;
    logic [OPW-1:0]    op;
    logic [SW-1:0]     sa, sb;
    logic              wb;
    logic [DW-1:0]     d;
    logic [COLS*W-1:0] avail;
    logic [W-1:0]      y;
    logic              live;

    assign sc = row_cfg[c*SLOT +: SLOT];
    assign op = sc[SLOT-1 -: OPW];
    assign sa = sc[SLOT-OPW-1 -: SW];
    assign sb = sc[SLOT-OPW-SW-1 -: SW];
    assign wb = sc[DW];
    assign d  = sc[DW-1:0];

    if (c == 0) begin : g_first
      assign avail = '0;
    end else begin : g_next
      assign avail = g_col[c-1].avail |
                     ({{((COLS-1)*W){1'b0}}, g_col[c-1].y} << ((c-1)*W));
    end

    assign live = (op != OP_OFF) && (op <= OP_PASS);
    assign y    = live ? alu_eval(op, pick(sa, ctx_flat, avail, c),
                                      pick(sb, ctx_flat, avail, c)) : '0;

    assign res[c*W +: W]   = y;
    assign wr[c]           = live & wb;
    assign dst[c*DW +: DW] = d;
  end
endmodule

// File: rtl/cgra_long_path.sv
`timescale 1ns/1ps
module cgra_long_path #(
  parameter int W    = 32,
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int MEMS = 2,
  parameter int AW   = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          fire,
  input  logic [NIN*W-1:0]                              ctx_flat,
  input  logic [2*$clog2(NIN)+$clog2(NOUT):0]           mul_cfg,
  input  logic [MEMS*($clog2(NIN)+$clog2(NOUT)+1)-1:0]  mem_cfg,
  input  logic [MEMS*W-1:0]                             ld_rdata,
  output logic [MEMS-1:0]                               ld_en,
  output logic [MEMS*AW-1:0]                            ld_addr,
  output logic [(1+MEMS)*W-1:0]                         val,
  output logic [MEMS:0]                                 wr,
  output logic [(1+MEMS)*$clog2(NOUT)-1:0]              dst
);
  localparam int IW   = $clog2(NIN);
  localparam int DW   = $clog2(NOUT);
  localparam int MULC = 1 + 2*IW + DW;
  localparam int MEMC = 1 + IW + DW;

  logic [IW-1:0] m_sa, m_sb;
  logic [W-1:0]  m_a, m_b, mul_q;

  assign m_sa = mul_cfg[MULC-2 -: IW];
  assign m_sb = mul_cfg[MULC-2-IW -: IW];
  assign m_a  = ctx_flat[int'(m_sa)*W +: W];
  assign m_b  = ctx_flat[int'(m_sb)*W +: W];

  always_ff @(posedge clk) begin
    if (rst)       mul_q <= '0;
    else if (fire) mul_q <= m_a * m_b;
  end

  assign val[W-1:0]  = mul_q;
  assign wr[0]       = mul_cfg[MULC-1];
  assign dst[DW-1:0] = mul_cfg[DW-1:0];

  for (genvar p = 0; p < MEMS; p++) begin : g_port
    logic [MEMC-1:0] pc;
    logic [IW-1:0]   sel;
    assign pc  = mem_cfg[p*MEMC +: MEMC];
    assign sel = pc[MEMC-2 -: IW];
    assign ld_en[p]               = fire & pc[MEMC-1];
    assign ld_addr[p*AW +: AW]    = ctx_flat[int'(sel)*W +: AW];
    assign val[(p+1)*W +: W]      = ld_rdata[p*W +: W];
    assign wr[p+1]                = pc[MEMC-1];
    assign dst[(p+1)*DW +: DW]    = pc[DW-1:0];
  end

  // R7
  ld_once_chk: assert property (@(posedge clk) disable iff (rst)
    (|ld_en) |=> !(|ld_en));
endmodule

// File: rtl/cgra_level.sv
`timescale 1ns/1ps
module cgra_level
  import cgra_level_pkg::*;
#(
  parameter int W    = 32,
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int ROWS = 4,
  parameter int COLS = 5,
  parameter int MEMS = 2,
  parameter int AW   = 8
) (
  input  logic                                                                   clk,
  input  logic                                                                   rst,
  input  logic                                                                   start,
  input  logic [NIN*W-1:0]                                                       ctx_in,
  input  logic [ROWS*COLS*(OPW+2*$clog2(NIN+COLS)+1+$clog2(NOUT))-1:0]           alu_cfg,
  input  logic [2*$clog2(NIN)+$clog2(NOUT):0]                                    mul_cfg,
  input  logic [MEMS*($clog2(NIN)+$clog2(NOUT)+1)-1:0]                           mem_cfg,
  input  logic [MEMS*W-1:0]                                                      ld_rdata,
  output logic [MEMS-1:0]                                                        ld_en,
  output logic [MEMS*AW-1:0]                                                     ld_addr,
  output logic [NOUT*W-1:0]                                                      out_ctx,
  output logic                                                                   done
);
  localparam int SW    = $clog2(NIN + COLS);
  localparam int DW    = $clog2(NOUT);
  localparam int IW    = $clog2(NIN);
  localparam int SLOT  = OPW + 2*SW + 1 + DW;
  localparam int NSLOT = ROWS * COLS;
  localparam int MULC  = 1 + 2*IW + DW;
  localparam int MEMC  = 1 + IW + DW;
  localparam int NLONG = 1 + MEMS;

  phase_e                 phase;
  logic                   long_q, done_q;
  logic [NIN*W-1:0]       in_q;
  logic [NSLOT*SLOT-1:0]  alu_cfg_q;
  logic [MULC-1:0]        mul_cfg_q;
  logic [MEMS*MEMC-1:0]   mem_cfg_q;
  logic [W-1:0]           out_q [NOUT];
  logic [W-1:0]           nxt   [NOUT];

  logic [NSLOT*W-1:0]     alu_res;
  logic [NSLOT-1:0]       alu_wr;
  logic [NSLOT*DW-1:0]    alu_dst;
  logic [NLONG*W-1:0]     long_val;
  logic [NLONG-1:0]       long_wr;
  logic [NLONG*DW-1:0]    long_dst;
  logic                   any_long_in, commit;

  always_comb begin
    any_long_in = mul_cfg[MULC-1];
    for (int p = 0; p < MEMS; p++) any_long_in |= mem_cfg[p*MEMC + MEMC - 1];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    cgra_alu_row #(.W(W), .NIN(NIN), .NOUT(NOUT), .COLS(COLS)) u_row (
      .ctx_flat (in_q),
      .row_cfg  (alu_cfg_q[r*COLS*SLOT +: COLS*SLOT]),
      .res      (alu_res[r*COLS*W +: COLS*W]),
      .wr       (alu_wr[r*COLS +: COLS]),
      .dst      (alu_dst[r*COLS*DW +: COLS*DW])
    );
  end

  cgra_long_path #(.W(W), .NIN(NIN), .NOUT(NOUT), .MEMS(MEMS), .AW(AW)) u_long (
    .clk      (clk),
    .rst      (rst),
    .fire     (phase == PH_FIRST),
    .ctx_flat (in_q),
    .mul_cfg  (mul_cfg_q),
    .mem_cfg  (mem_cfg_q),
    .ld_rdata (ld_rdata),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .val      (long_val),
    .wr       (long_wr),
    .dst      (long_dst)
  );

  assign commit = ((phase == PH_FIRST) && !long_q) || (phase == PH_SECOND);

  // write-back merge, later slots override earlier ones
  always_comb begin
    for (int i = 0; i < NOUT; i++) nxt[i] = out_q[i];
    if (commit) begin
      for (int i = 0; i < NSLOT; i++)
        if (alu_wr[i] && int'(alu_dst[i*DW +: DW]) < NOUT)
          nxt[alu_dst[i*DW +: DW]] = alu_res[i*W +: W];
      if (phase == PH_SECOND)
        for (int k = 0; k < NLONG; k++)
          if (long_wr[k] && int'(long_dst[k*DW +: DW]) < NOUT)
            nxt[long_dst[k*DW +: DW]] = long_val[k*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      long_q    <= 1'b0;
      done_q    <= 1'b0;
      in_q      <= '0;
      alu_cfg_q <= '0;
      mul_cfg_q <= '0;
      mem_cfg_q <= '0;
      for (int i = 0; i < NOUT; i++) out_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      for (int i = 0; i < NOUT; i++) out_q[i] <= nxt[i];
      case (phase)
        PH_IDLE: if (start) begin
          in_q      <= ctx_in;
          alu_cfg_q <= alu_cfg;
          mul_cfg_q <= mul_cfg;
          mem_cfg_q <= mem_cfg;
          long_q    <= any_long_in;
          phase     <= PH_FIRST;
        end
        PH_FIRST: begin
          if (long_q) phase <= PH_SECOND;
          else begin
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        PH_SECOND: begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign out_ctx[i*W +: W] = out_q[i];
  end
  assign done = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(out_ctx));
  // R4
  short_done_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FIRST && !long_q) |=> done);
  // R8
  long_done_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SECOND) |=> done);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && phase != PH_IDLE) |=> (phase != PH_FIRST));
endmodule

// File: tb/sim_cgra_level.sv
`timescale 1ns/1ps
module sim_cgra_level;
  localparam int W = 32, NIN = 8, NOUT = 8, ROWS = 4, COLS = 5, MEMS = 2, AW = 8;

  logic clk = 1'b0;
  logic rst, start;
  logic [NIN*W-1:0]         ctx;
  logic [ROWS*COLS*16-1:0]  acfg;
  logic [9:0]               mcfg;
  logic [MEMS*7-1:0]        qcfg;
  logic [MEMS*W-1:0]        rdata;
  logic [MEMS-1:0]          ld_en;
  logic [MEMS*AW-1:0]       ld_addr;
  logic [NOUT*W-1:0]        outv;
  logic                     done;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cgra_level #(.W(W), .NIN(NIN), .NOUT(NOUT), .ROWS(ROWS), .COLS(COLS),
               .MEMS(MEMS), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .ctx_in(ctx), .alu_cfg(acfg),
    .mul_cfg(mcfg), .mem_cfg(qcfg), .ld_rdata(rdata), .ld_en(ld_en),
    .ld_addr(ld_addr), .out_ctx(outv), .done(done));

  // data memory model: registered read, word = addr*5+3
  always @(posedge clk)
    for (int p = 0; p < MEMS; p++)
      if (ld_en[p]) rdata[p*W +: W] <= {24'b0, ld_addr[p*AW +: AW]} * 5 + 3;

  function automatic logic [15:0] aslot(input int op, input int sa, input int sb,
                                        input int wb, input int d);
    return {op[3:0], sa[3:0], sb[3:0], wb[0], d[2:0]};
  endfunction

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a,
                                          input logic [31:0] b);
    case (op)
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return a << b[4:0];
      7: return a >> b[4:0];
      8: return $signed(a) >>> b[4:0];
      9: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      10: return (a < b) ? 32'd1 : 32'd0;
      11: return a;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] oget(input int i);
    return outv[i*W +: W];
  endfunction

  task automatic setc(input int i, input logic [31:0] v);
    ctx[i*W +: W] = v;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clear_cfg();
    acfg = '0; mcfg = '0; qcfg = '0;
  endtask

  task automatic go(input int lat, input logic [1:0] emask, input string r);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(r, {31'b0, done}, 32'd0);
    if (lat == 2) begin
      chk("R7 ld_en", {30'b0, ld_en}, {30'b0, emask});
      @(negedge clk);
      chk(r, {31'b0, done}, 32'd0);
      chk("R7 ld_en drop", {30'b0, ld_en}, 32'd0);
    end
    @(negedge clk);
    chk(r, {31'b0, done}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] av [6];
    logic [31:0] bv [6];
    logic [31:0] e2, c0, c1, c2, c3, c4;
    logic [63:0] prod;
    rst = 1'b1; start = 1'b0; ctx = '0; rdata = '0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NOUT; i++) chk("R1 out", oget(i), 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 ld_en", {30'b0, ld_en}, 32'd0);

    // R2 / R9 op sweep on slot 0: ctx0 op ctx1 -> word 2
    av = '{32'd5, 32'hFFFF_FFF0, 32'h8000_0001, 32'd0, 32'd7, 32'h1234_5678};
    bv = '{32'd3, 32'd4, 32'd31, 32'd0, 32'hFFFF_FFFF, 32'h0000_0020};
    e2 = 32'd0;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 6; k++) begin
        clear_cfg();
        setc(0, av[k]); setc(1, bv[k]);
        acfg[0 +: 16] = aslot(op, 0, 1, 1, 2);
        go(1, 2'b00, "R4 short done");
        if (op >= 1 && op <= 11) begin
          e2 = ref_alu(op, av[k], bv[k]);
          chk("R2 op result", oget(2), e2);
        end else
          chk("R9 disabled op keeps word", oget(2), e2);
      end
    end

    // R4 five-deep chain in row 0, R3 forward / out-of-range selects
    clear_cfg();
    setc(0, 32'd10); setc(1, 32'd20); setc(2, 32'd7); setc(3, 32'hF0); setc(4, 32'd3);
    acfg[0*16 +: 16] = aslot(1, 0, 1, 0, 0);
    acfg[1*16 +: 16] = aslot(1, 8, 2, 0, 0);
    acfg[2*16 +: 16] = aslot(5, 9, 3, 0, 0);
    acfg[3*16 +: 16] = aslot(6, 10, 4, 0, 0);
    acfg[4*16 +: 16] = aslot(2, 11, 8, 1, 5);
    acfg[6*16 +: 16] = aslot(1, 11, 2, 1, 6);   // column 3 referenced from column 1
    acfg[10*16 +: 16] = aslot(4, 15, 3, 1, 7);  // select beyond range
    go(1, 2'b00, "R4 chain done");
    c0 = 32'd10 + 32'd20; c1 = c0 + 32'd7; c2 = c1 ^ 32'hF0; c3 = c2 << 3; c4 = c3 - c0;
    chk("R4 chain result", oget(5), c4);
    chk("R3 forward ref reads zero", oget(6), 32'd7);
    chk("R3 out-of-range reads zero", oget(7), 32'hF0);
    chk("R9 wb=0 keeps word 0", oget(0), 32'd0);

    // R5 parallel rows
    clear_cfg();
    setc(0, 32'd100); setc(1, 32'd42); setc(2, 32'h3C); setc(3, 32'hF5);
    acfg[0*16 +: 16]  = aslot(1, 0, 1, 1, 0);
    acfg[5*16 +: 16]  = aslot(2, 0, 1, 1, 1);
    acfg[10*16 +: 16] = aslot(3, 2, 3, 1, 3);
    acfg[15*16 +: 16] = aslot(10, 1, 0, 1, 4);
    go(1, 2'b00, "R5 rows done");
    chk("R5 row0", oget(0), 32'd142);
    chk("R5 row1", oget(1), 32'd58);
    chk("R5 row2", oget(3), 32'h34);
    chk("R5 row3", oget(4), 32'd1);

    // R10 ALU slot order on a shared destination
    clear_cfg();
    acfg[0*16 +: 16]  = aslot(1, 0, 1, 1, 3);
    acfg[19*16 +: 16] = aslot(2, 0, 1, 1, 3);
    go(1, 2'b00, "R10 done");
    chk("R10 higher slot wins", oget(3), 32'd58);

    // R6 R7 R8 multiplier and loads, R10 multiplier over ALU
    clear_cfg();
    setc(0, 32'h0001_2345); setc(1, 32'h0001_0001); setc(2, 32'h1FF); setc(3, 32'h42);
    mcfg = {1'b1, 3'd0, 3'd1, 3'd0};
    qcfg[0 +: 7] = {1'b1, 3'd2, 3'd1};
    qcfg[7 +: 7] = {1'b1, 3'd3, 3'd4};
    acfg[2*16 +: 16] = aslot(11, 3, 0, 1, 0);
    acfg[0*16 +: 16] = aslot(1, 0, 1, 1, 6);
    go(2, 2'b11, "R8 long done");
    prod = 64'h0001_2345 * 64'h0001_0001;
    chk("R6 product low bits", oget(0), prod[31:0]);
    chk("R7 load port 0", oget(1), 32'hFF * 5 + 3);
    chk("R7 load port 1", oget(4), 32'h42 * 5 + 3);
    chk("R7 address low bits", {24'b0, ld_addr[7:0]}, 32'hFF);
    chk("R8 ALU lands with long", oget(6), 32'h0002_2346);

    // R10 load port 1 over port 0, loads alone still take two cycles
    clear_cfg();
    setc(2, 32'h10); setc(3, 32'h20);
    qcfg[0 +: 7] = {1'b1, 3'd2, 3'd7};
    qcfg[7 +: 7] = {1'b1, 3'd3, 3'd7};
    go(2, 2'b11, "R8 load-only done");
    chk("R10 port 1 wins", oget(7), 32'h20 * 5 + 3);

    // R11 R12 start while busy, inputs changed after start
    clear_cfg();
    setc(0, 32'd6); setc(1, 32'd7);
    mcfg = {1'b1, 3'd0, 3'd1, 3'd5};
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    chk("R11 done", {31'b0, done}, 32'd0);
    setc(0, 32'd100); mcfg = {1'b1, 3'd0, 3'd1, 3'd2};
    @(negedge clk); start = 1'b0;
    chk("R11 done", {31'b0, done}, 32'd0);
    @(negedge clk);
    chk("R11 done", {31'b0, done}, 32'd1);
    chk("R12 first result kept", oget(5), 32'd42);
    chk("R11 second start dropped", oget(2), e2);
    @(negedge clk);
    chk("R8 done single cycle", {31'b0, done}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule